// File: doc/BRIEF.md
# Edge-Selectable Port Interrupt Flags

This block turns level changes on an 8-bit input port into sticky per-pin interrupt flags and one combined request line for a downstream interrupt controller. Each pin is first passed through a two-flop synchronizer. The block then compares the synchronized value with the value from the previous cycle to find rising and falling transitions. A per-pin polarity bit chooses which transition counts for that pin.

Three registers are reached through a small single-cycle register bus: an enable mask, a polarity mask and the flag register. A flag latches its selected transition whether or not its pin is enabled. The request output is high while any pin has both its flag and its enable set. Software clears a flag by writing 1 to its bit. Firmware is expected to clear stale flags before it enables a pin, so that no spurious request appears.

A short arming window after reset stops the synchronizer's fill from being taken as a transition. Without it, a pin that is already high when reset ends would set its flag.

Top module: `gpio_irq_flags`

## Requirements
- R1: After reset, the enable (address 0), polarity (address 1) and flag (address 2) registers all read 0, and `irq` is low.
- R2: Writing address 0 loads the enable mask from `bus_wdata` (bit i belongs to pin i), and reading address 0 returns the mask.
- R3: Writing address 1 loads the polarity mask, and reading it returns the mask. A polarity bit of 0 makes a rising transition qualify for that pin, and a polarity bit of 1 makes a falling transition qualify.
- R4: A qualifying transition on `pin_in[i]` sets flag bit i at the third rising clock edge after the input changes, and the flag is visible on a read of address 2 from then on. A transition of the other direction leaves the flag unchanged.
- R5: A flag is set by its qualifying transition even while its enable bit is 0. In that case `irq` stays low.
- R6: `irq` is high in the same cycle in which any pin has both its flag bit and its enable bit at 1. It stays high until every such flag is cleared or its enable bit is removed.
- R7: Writing address 2 clears each flag whose `bus_wdata` bit is 1. Bits written as 0 leave their flags unchanged, and a write can never set a flag.
- R8: When a qualifying transition and a write-1 clear hit the same flag at the same clock edge, the flag ends up set.
- R9: Transitions are not recognized during the first three clock edges after reset is released. A pin held high through reset does not set its flag.
- R10: Transitions on several pins in the same cycle each set their own flag. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous port input pins |
| bus_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register address (0 enable, 1 polarity, 2 flags, 3 reserved) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | Combined level interrupt request |

## Verification
A pin change reaches its flag three rising edges after the change: two synchronizer stages, then the flag register. The bench therefore drives pins on a falling edge and reads the flag both two and three falling edges later. It expects the flag to be clear at the first read and set at the second. Register writes take effect at the single rising edge inside the write strobe, and `irq` follows flags and enables with no further delay. The read-back checks are made combinationally, right after the falling edge that closes each write. The set-versus-clear case puts the clear strobe on exactly the rising edge on which the synchronized transition is present.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants for the port interrupt flag block.
// Assumes a 2-bit word address on the register bus.
package gpio_irq_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_POLARITY = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS    = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_RSVD     = 2'd3;
endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 2. Each bit is synchronized on its own, so bits that
// change together may arrive one cycle apart.
module gpio_irq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge.sv
// Module: per-pin transition detector with selectable polarity.
// Assumes `level` is already synchronous. Detection stays off until
// WARMUP edges after reset, when both the current and the previous
// samples come from real input data.
module gpio_irq_edge #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned WARMUP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] fall_sel,
    output logic [WIDTH-1:0] hit
);
    localparam int unsigned CNT_W = $clog2(WARMUP + 1);

    logic [WIDTH-1:0] prev_q;
    logic [CNT_W-1:0] warm_q;
    logic             armed;

    assign armed = (warm_q == CNT_W'(WARMUP));

    // Remember last cycle's level, and count the arming window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            warm_q <= '0;
        end else begin
            prev_q <= level;
            if (!armed) begin
                warm_q <= warm_q + 1'b1;
            end
        end
    end

    // One comparator per pin; the polarity bit picks the direction.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic rise;
        logic fall;
        assign rise   = level[i] & ~prev_q[i];
        assign fall   = ~level[i] & prev_q[i];
        assign hit[i] = armed & (fall_sel[i] ? fall : rise);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
// Module: enable, polarity and sticky flag registers with bus access.
// Assumes a single-cycle write strobe. A transition that sets a flag wins
// over a write-1 clear of that flag at the same edge.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  hit,
    output logic [WIDTH-1:0]  en_q,
    output logic [WIDTH-1:0]  fall_sel_q,
    output logic [WIDTH-1:0]  flag_q,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] clr_mask;

    // Form the write-1-clear mask for the flag register.
    always_comb begin
        clr_mask = '0;
        if (bus_we && bus_addr == ADDR_FLAGS) begin
            clr_mask = bus_wdata;
        end
    end

    // Load the configuration registers from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            fall_sel_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_ENABLE) begin
                en_q <= bus_wdata;
            end
            if (bus_addr == ADDR_POLARITY) begin
                fall_sel_q <= bus_wdata;
            end
        end
    end

    // Update the sticky flags: clear first, then set, so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | hit;
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            ADDR_ENABLE:   rdata = en_q;
            ADDR_POLARITY: rdata = fall_sel_q;
            ADDR_FLAGS:    rdata = flag_q;
            default:       rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_flags.sv
// Module: top level of the port interrupt flag block.
// Assumes asynchronous pin inputs that have already been debounced, and a
// controller that takes a level-sensitive request.
module gpio_irq_flags #(
    parameter int unsigned N_PINS      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_PINS-1:0]               pin_in,
    input  logic                            bus_we,
    input  logic [gpio_irq_pkg::ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0]               bus_wdata,
    output logic [N_PINS-1:0]               bus_rdata,
    output logic                            irq
);
    localparam int unsigned WARMUP = SYNC_STAGES + 1;

    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] edge_hit;
    logic [N_PINS-1:0] en_q;
    logic [N_PINS-1:0] fall_sel_q;
    logic [N_PINS-1:0] flag_q;

    gpio_irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    gpio_irq_edge #(.WIDTH(N_PINS), .WARMUP(WARMUP)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_sync),
        .fall_sel (fall_sel_q),
        .hit      (edge_hit)
    );

    gpio_irq_regs #(.WIDTH(N_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .hit        (edge_hit),
        .en_q       (en_q),
        .fall_sel_q (fall_sel_q),
        .flag_q     (flag_q),
        .rdata      (bus_rdata)
    );

    // Combine every enabled flag onto the one request line.
    assign irq = |(flag_q & en_q);
endmodule

// File: rtl/gpio_irq_flags_chk.sv
// Module: assertion checker for gpio_irq_flags, attached with bind.
// Assumes the internal names en_q, flag_q and edge_hit in the top module.
module gpio_irq_flags_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned WARMUP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic              irq,
    input logic [N_PINS-1:0] en_q,
    input logic [N_PINS-1:0] flag_q,
    input logic [N_PINS-1:0] hit
);
    localparam int unsigned CW = $clog2(WARMUP + 1);
    logic [CW-1:0] since_rst;

    // Count the clock edges since reset, saturating at WARMUP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != CW'(WARMUP)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0 && en_q == '0 && !irq)); // R1
    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_ENABLE) |=> (en_q == $past(bus_wdata))); // R2
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0)); // R6
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_we) |=> irq); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_FLAGS) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit))); // R8
    AST_COLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != CW'(WARMUP)) |-> (hit == '0)); // R9
endmodule

bind gpio_irq_flags gpio_irq_flags_chk #(.N_PINS(N_PINS), .WARMUP(SYNC_STAGES + 1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .hit       (edge_hit)
);

// File: tb/gpio_irq_flags_test.sv
module gpio_irq_flags_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'h80;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd2;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    gpio_irq_flags uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Combinational read, called just after a falling edge.
    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic drive_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    // Drive pins, then confirm the flags are due on the third edge and not before.
    task automatic pins_and_wait(input string req, input logic [7:0] v,
                                 input logic [7:0] flags_before, input logic [7:0] flags_after);
        logic [7:0] d;
        drive_pins(v);
        repeat (2) @(negedge clk);
        peek(2'd2, d);
        check({req, " flags before third edge"}, d, flags_before);
        @(negedge clk);
        peek(2'd2, d);
        check({req, " flags at third edge"}, d, flags_after);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(2'd0, d); check("R1 enable reset", d, 8'h00);
        peek(2'd1, d); check("R1 polarity reset", d, 8'h00);
        peek(2'd2, d); check("R1 flags reset", d, 8'h00);
        check("R1 irq reset", irq, 1'b0);
        repeat (8) @(negedge clk);
        peek(2'd2, d); check("R9 pin high through reset gives no flag", d, 8'h00);
        // Pin 7 falls while rising is selected: the other direction is ignored.
        pins_and_wait("R4 opposite edge", 8'h00, 8'h00, 8'h00);
        repeat (2) @(negedge clk);
        peek(2'd2, d); check("R4 opposite edge stays clear", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        bus_write(2'd0, 8'hA5);
        peek(2'd0, d); check("R2 enable readback", d, 8'hA5);
        bus_write(2'd1, 8'h5A);
        peek(2'd1, d); check("R3 polarity readback", d, 8'h5A);
        peek(2'd3, d); check("R10 reserved address reads zero", d, 8'h00);
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'hFF);
        peek(2'd2, d); check("R7 write cannot set flags", d, 8'h00);
    endtask

    task automatic t_rise_masked();
        logic [7:0] d;
        pins_and_wait("R4 rising pin0", 8'h01, 8'h00, 8'h01);
        check("R5 masked flag keeps irq low", irq, 1'b0);
        pins_and_wait("R4 falling pin0 ignored", 8'h00, 8'h01, 8'h01);
        bus_write(2'd0, 8'h01);
        check("R6 irq after enabling flagged pin", irq, 1'b1);
        bus_write(2'd2, 8'h00);
        peek(2'd2, d); check("R7 zero write keeps flag", d, 8'h01);
        check("R6 irq held", irq, 1'b1);
        bus_write(2'd2, 8'h01);
        peek(2'd2, d); check("R7 write one clears flag", d, 8'h00);
        check("R6 irq drops after clear", irq, 1'b0);
        bus_write(2'd0, 8'h00);
    endtask

    task automatic t_fall();
        bus_write(2'd1, 8'h02);
        pins_and_wait("R3 rising ignored with falling select", 8'h02, 8'h00, 8'h00);
        pins_and_wait("R3 falling sets flag", 8'h00, 8'h00, 8'h02);
        bus_write(2'd0, 8'h02);
        check("R6 irq same cycle as enabled flag", irq, 1'b1);
        bus_write(2'd2, 8'h02);
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_multi();
        logic [7:0] d;
        bus_write(2'd0, 8'hFF);
        drive_pins(8'h3C);
        repeat (2) @(negedge clk);
        check("R6 irq low before flags", irq, 1'b0);
        @(negedge clk);
        peek(2'd2, d); check("R10 several pins flag together", d, 8'h3C);
        check("R6 irq with enabled flags", irq, 1'b1);
        bus_write(2'd2, 8'h04);
        peek(2'd2, d); check("R7 partial clear", d, 8'h38);
        check("R6 irq level while flags remain", irq, 1'b1);
        bus_write(2'd0, 8'h00);
        check("R6 irq drops when enables removed", irq, 1'b0);
        bus_write(2'd2, 8'hFF);
        drive_pins(8'h00);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        pins_and_wait("R4 rising pin6", 8'h40, 8'h00, 8'h40);
        bus_write(2'd1, 8'h40);
        drive_pins(8'h00);
        @(negedge clk);
        @(negedge clk);
        // The transition is present at the next rising edge; strobe the clear there.
        bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h40;
        @(negedge clk);
        bus_we = 1'b0;
        peek(2'd2, d); check("R8 set wins over same-edge clear", d, 8'h40);
        bus_write(2'd2, 8'h40);
        peek(2'd2, d); check("R8 later clear works", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_rise_masked();
        t_fall();
        t_multi();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule